// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block carries words between two clock domains whose clocks have no relation to each other. A producer pushes words on the write clock and a consumer pulls them on the read clock. Each side has its own status outputs, and every one of those outputs changes only on the clock of its own side. On the write side these are full, almost-full, a programmable-full level and an occupancy count. On the read side they are empty, almost-empty, a programmable-empty level and an occupancy count. Each transfer is confirmed: an accepted write raises an acknowledge, and an accepted read raises a valid strobe aligned with the data. A rejected write raises a one-cycle overflow strobe, and a rejected read raises a one-cycle underflow strobe.

Reads use standard mode: the word appears on the registered data output one read clock after the request. A single reset input, active high, is synchronised into each domain. The write side then holds its full-type flags high for a fixed recovery window, so a producer that waits for full to drop never writes before the FIFO is ready. The pointers cross between domains as Gray codes through two-stage synchronisers. Each side therefore sees the other side's progress a few clocks late, which can make full or empty stay asserted longer than the true state, but never release either one too early.

Top module: `dcfifo_flags`

## Requirements
- R1: The reset input is sampled by two write-clock flops. While it is active, and until three write clocks after the synchronised copy falls, wr_full, wr_almost_full and wr_prog_full are high and writes are ignored (no wr_ack, no wr_overflow). If reset is released between edges, the flags are still high after the 4th rising write-clock edge, low after the 5th, and a held write is first accepted at the 6th. During reset wr_level is 0.
- R2: Outside recovery, wr_ack is high in exactly the cycle after a write that was accepted. Every write request yields exactly one of wr_ack or wr_overflow, and neither strobe appears without a request.
- R3: A write requested while the write side sees DEPTH words is dropped, wr_overflow pulses for that one cycle, and the stored contents are not changed.
- R4: wr_level is a register holding the write-side occupancy of the previous cycle, so an accepted write shows up in it two write clocks after the request.
- R5: wr_full is high while the write side sees DEPTH words. wr_almost_full is high while it sees DEPTH-1 or more, so in a back-to-back burst it rises one write clock before wr_full.
- R6: wr_prog_full is high while wr_level >= PROG_FULL_AT (253 by default).
- R7: In standard read mode, rd_data and rd_valid change one read clock after a read request that finds data. Words leave in the order they were accepted.
- R8: A read requested while empty raises rd_underflow for one read clock with rd_valid low, and rd_data keeps its previous value.
- R9: rd_empty is high while the read side sees no words. rd_almost_empty is high when it sees exactly one. During reset rd_empty is high.
- R10: rd_level is a register holding the read-side occupancy of the previous read clock. rd_prog_empty is high while rd_level <= PROG_EMPTY_AT (2 by default).
- R11: Each Gray pointer changes by at most one bit per clock. Under concurrent traffic on both clocks no word is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock, unrelated to wr_clk |
| rst | input | 1 | Reset, active high, synchronised into both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Write side sees DEPTH words (or recovery) |
| wr_almost_full | output | 1 | At most one free slot (or recovery) |
| wr_prog_full | output | 1 | wr_level at or above threshold (or recovery) |
| wr_ack | output | 1 | Previous-cycle write was stored |
| wr_overflow | output | 1 | Previous-cycle write was dropped |
| wr_level | output | ADDR_W+1 | Registered write-side occupancy |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | rd_data holds a freshly read word |
| rd_underflow | output | 1 | Previous-cycle read found the FIFO empty |
| rd_empty | output | 1 | Read side sees no words |
| rd_almost_empty | output | 1 | Read side sees exactly one word |
| rd_prog_empty | output | 1 | rd_level at or below threshold |
| rd_level | output | ADDR_W+1 | Registered read-side occupancy |

## Verification
The bench builds the block with ADDR_W=4, so the FIFO is 16 deep, with PROG_FULL_AT=13 and PROG_EMPTY_AT=2. With these values a short burst reaches full, overflow, both programmable thresholds, almost-empty and underflow, and the random phases wrap the pointers many times. The write clock runs at 200 MHz and the read clock at an unrelated slower rate. Runs with a fast writer and a slow reader, then the reverse, push the FIFO against both the full and the empty boundary while both pointers are crossing domains at the same time.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    // write clocks the full-side flags stay held after reset synchronisation
    localparam int unsigned RECOVERY_CYCLES = 3;
    // flops in every clock-crossing chain
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic prog_full;
    } wr_level_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
        logic prog_empty;
    } rd_level_t;
endpackage

// File: rtl/fifo_sync_chain.sv
`timescale 1ns/1ps
module fifo_sync_chain #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fifo_dpram.sv
`timescale 1ns/1ps
module fifo_dpram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // registered read port: output only moves on an accepted read
    always_ff @(posedge rclk) begin
        if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/1ps
module fifo_wr_side import dcf_pkg::*; #(
    parameter int ADDR_W       = 8,
    parameter int PROG_FULL_AT = 253
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              mem_we,
    output logic              wr_ack,
    output logic              wr_overflow,
    output wr_level_t         lvl,
    output logic [ADDR_W:0]   wr_level
);
    localparam int PW  = ADDR_W + 1;
    localparam int RCW = $clog2(RECOVERY_CYCLES + 1);
    localparam logic [PW-1:0]  ONE       = PW'(1);
    localparam logic [PW-1:0]  FULL_LVL  = ONE << ADDR_W;
    localparam logic [PW-1:0]  AFULL_LVL = FULL_LVL - ONE;
    localparam logic [PW-1:0]  PF_LVL    = PW'(PROG_FULL_AT);
    localparam logic [RCW-1:0] RECOV_INIT = RCW'(RECOVERY_CYCLES);

    logic [PW-1:0]  wbin_q, wgray_q, wbin_nxt, rbin_seen, occ_now, level_q;
    logic [RCW-1:0] recov_q;
    logic           busy, at_full, fire, ack_q, ovf_q;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_seen[i] = ^(rgray_sync >> i);
        occ_now  = wbin_q - rbin_seen;
        at_full  = (occ_now == FULL_LVL);
        busy     = srst || (recov_q != '0);
        fire     = wr_en && !busy && !at_full;
        wbin_nxt = wbin_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            recov_q <= RECOV_INIT;
            ack_q   <= 1'b0;
            ovf_q   <= 1'b0;
            level_q <= '0;
        end else begin
            if (recov_q != '0) recov_q <= recov_q - RCW'(1);
            if (fire) begin
                wbin_q  <= wbin_nxt;
                wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
            end
            ack_q   <= fire;
            ovf_q   <= wr_en && !busy && at_full;
            level_q <= occ_now;
        end
    end

    assign wgray            = wgray_q;
    assign waddr            = wbin_q[ADDR_W-1:0];
    assign mem_we           = fire;
    assign wr_ack           = ack_q;
    assign wr_overflow      = ovf_q;
    assign wr_level         = level_q;
    assign lvl.full         = busy || at_full;
    assign lvl.almost_full  = busy || (occ_now >= AFULL_LVL);
    assign lvl.prog_full    = busy || (level_q >= PF_LVL);

    AST_ACK_NEEDS_REQ:    assert property (@(posedge clk) disable iff (srst) wr_ack |-> $past(wr_en));             // R2
    AST_ACK_OR_OVF:       assert property (@(posedge clk) disable iff (srst) !(wr_ack && wr_overflow));           // R2
    AST_OVF_WHEN_FULL:    assert property (@(posedge clk) disable iff (srst) wr_overflow |-> $past(lvl.full));    // R3
    AST_LEVEL_BOUND:      assert property (@(posedge clk) disable iff (srst) wr_level <= FULL_LVL);               // R4
    AST_ALMOST_FULL_FIRST: assert property (@(posedge clk) disable iff (srst) $rose(lvl.full) |-> $past(lvl.almost_full)); // R5
    AST_WGRAY_STEP:       assert property (@(posedge clk) disable iff (srst) $countones(wgray_q ^ $past(wgray_q)) <= 1); // R11
endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/1ps
module fifo_rd_side import dcf_pkg::*; #(
    parameter int ADDR_W        = 8,
    parameter int PROG_EMPTY_AT = 2
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic              mem_re,
    output logic              rd_valid,
    output logic              rd_underflow,
    output rd_level_t         lvl,
    output logic [ADDR_W:0]   rd_level
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] ONE    = PW'(1);
    localparam logic [PW-1:0] PE_LVL = PW'(PROG_EMPTY_AT);

    logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wbin_seen, occ_now, level_q;
    logic          is_empty, fire, valid_q, udf_q;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_seen[i] = ^(wgray_sync >> i);
        occ_now  = wbin_seen - rbin_q;
        is_empty = (occ_now == '0);
        fire     = rd_en && !is_empty;
        rbin_nxt = rbin_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            valid_q <= 1'b0;
            udf_q   <= 1'b0;
            level_q <= '0;
        end else begin
            if (fire) begin
                rbin_q  <= rbin_nxt;
                rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
            end
            valid_q <= fire;
            udf_q   <= rd_en && is_empty;
            level_q <= occ_now;
        end
    end

    assign rgray            = rgray_q;
    assign raddr            = rbin_q[ADDR_W-1:0];
    assign mem_re           = fire;
    assign rd_valid         = valid_q;
    assign rd_underflow     = udf_q;
    assign rd_level         = level_q;
    assign lvl.empty        = is_empty;
    assign lvl.almost_empty = (occ_now == ONE);
    assign lvl.prog_empty   = (level_q <= PE_LVL);

    AST_VALID_NEEDS_REQ:  assert property (@(posedge clk) disable iff (srst) rd_valid |-> $past(rd_en));            // R7
    AST_VALID_HAD_DATA:   assert property (@(posedge clk) disable iff (srst) rd_valid |-> !$past(lvl.empty));      // R7
    AST_UDF_WHEN_EMPTY:   assert property (@(posedge clk) disable iff (srst) rd_underflow |-> $past(lvl.empty));   // R8
    AST_EMPTY_EXCLUSIVE:  assert property (@(posedge clk) disable iff (srst) !(lvl.empty && lvl.almost_empty));   // R9
    AST_RGRAY_STEP:       assert property (@(posedge clk) disable iff (srst) $countones(rgray_q ^ $past(rgray_q)) <= 1); // R11
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/1ps
module dcfifo_flags import dcf_pkg::*; #(
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 8,
    parameter int PROG_FULL_AT  = 253,
    parameter int PROG_EMPTY_AT = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_almost_full,
    output logic              wr_prog_full,
    output logic              wr_ack,
    output logic              wr_overflow,
    output logic [ADDR_W:0]   wr_level,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_underflow,
    output logic              rd_empty,
    output logic              rd_almost_empty,
    output logic              rd_prog_empty,
    output logic [ADDR_W:0]   rd_level
);
    localparam int PW = ADDR_W + 1;

    logic              wr_srst, rd_srst, mem_we, mem_re;
    logic [PW-1:0]     wgray, rgray, wgray_at_rd, rgray_at_wr;
    logic [ADDR_W-1:0] waddr, raddr;
    wr_level_t         wlvl;
    rd_level_t         rlvl;

    fifo_sync_chain #(.W(1), .STAGES(SYNC_STAGES)) u_wr_rst_sync (
        .clk(wr_clk), .clr(1'b0), .d(rst), .q(wr_srst));
    fifo_sync_chain #(.W(1), .STAGES(SYNC_STAGES)) u_rd_rst_sync (
        .clk(rd_clk), .clr(1'b0), .d(rst), .q(rd_srst));
    fifo_sync_chain #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_to_wr (
        .clk(wr_clk), .clr(wr_srst), .d(rgray), .q(rgray_at_wr));
    fifo_sync_chain #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_to_rd (
        .clk(rd_clk), .clr(rd_srst), .d(wgray), .q(wgray_at_rd));

    fifo_wr_side #(.ADDR_W(ADDR_W), .PROG_FULL_AT(PROG_FULL_AT)) u_wr (
        .clk(wr_clk), .srst(wr_srst), .wr_en(wr_en), .rgray_sync(rgray_at_wr),
        .wgray(wgray), .waddr(waddr), .mem_we(mem_we), .wr_ack(wr_ack),
        .wr_overflow(wr_overflow), .lvl(wlvl), .wr_level(wr_level));

    fifo_rd_side #(.ADDR_W(ADDR_W), .PROG_EMPTY_AT(PROG_EMPTY_AT)) u_rd (
        .clk(rd_clk), .srst(rd_srst), .rd_en(rd_en), .wgray_sync(wgray_at_rd),
        .rgray(rgray), .raddr(raddr), .mem_re(mem_re), .rd_valid(rd_valid),
        .rd_underflow(rd_underflow), .lvl(rlvl), .rd_level(rd_level));

    fifo_dpram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .re(mem_re), .raddr(raddr), .rdata(rd_data));

    assign wr_full         = wlvl.full;
    assign wr_almost_full  = wlvl.almost_full;
    assign wr_prog_full    = wlvl.prog_full;
    assign rd_empty        = rlvl.empty;
    assign rd_almost_empty = rlvl.almost_empty;
    assign rd_prog_empty   = rlvl.prog_empty;

    AST_UDF_KEEPS_DATA: assert property (@(posedge rd_clk) disable iff (rd_srst) rd_underflow |-> (!rd_valid && $stable(rd_data))); // R8
endmodule

// File: tb/dcfifo_flags_tb.sv
`timescale 1ns/1ps
module dcfifo_flags_tb;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int PF    = 13;
    localparam int PE    = 2;

    logic wclk = 1'b0, rclk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic wr_full, wr_almost_full, wr_prog_full, wr_ack, wr_overflow;
    logic rd_valid, rd_underflow, rd_empty, rd_almost_empty, rd_prog_empty;
    logic [AW:0] wr_level, rd_level;
    logic [DW-1:0] rd_data;

    always #2.5 wclk = ~wclk;   // 200 MHz
    always #3.5 rclk = ~rclk;

    dcfifo_flags #(.DATA_W(DW), .ADDR_W(AW), .PROG_FULL_AT(PF), .PROG_EMPTY_AT(PE)) u_dut (
        .wr_clk(wclk), .rd_clk(rclk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_almost_full(wr_almost_full), .wr_prog_full(wr_prog_full),
        .wr_ack(wr_ack), .wr_overflow(wr_overflow), .wr_level(wr_level),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_underflow(rd_underflow),
        .rd_empty(rd_empty), .rd_almost_empty(rd_almost_empty), .rd_prog_empty(rd_prog_empty),
        .rd_level(rd_level));

    int checks = 0, errors = 0;
    int w_acc = 0, r_acc = 0, w_occ_prev = 0, r_occ_prev = 0, rel_cnt = 0;
    bit exact_w = 0, exact_r = 0, done = 0;
    logic [DW-1:0] sb[$];
    logic [DW-1:0] last_dout = '0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int b2i(input logic b);
        return b ? 1 : 0;
    endfunction

    // write-side monitor, 1 ns after each write edge
    always @(posedge wclk) begin
        #1;
        if (rst) begin
            rel_cnt = 0;
        end else begin
            if (rel_cnt < 1000) rel_cnt++;
            if (rel_cnt <= 5) begin
                chk("R1", "no ack in recovery", b2i(wr_ack), 0);
                chk("R1", "no overflow in recovery", b2i(wr_overflow), 0);
                if (rel_cnt == 4) chk("R1", "flags held edge4", int'({wr_full, wr_almost_full, wr_prog_full}), 7);
                if (rel_cnt == 5) chk("R1", "flags free edge5", int'({wr_full, wr_almost_full, wr_prog_full}), 0);
            end else begin
                if (wr_en) chk("R2", "ack xor overflow", b2i(wr_ack ^ wr_overflow), 1);
                else       chk("R2", "idle strobes", b2i(wr_ack | wr_overflow), 0);
                if (exact_w) begin
                    chk("R2", "ack expected", b2i(wr_ack), b2i(wr_en && w_occ_prev < DEPTH));
                    chk("R3", "overflow expected", b2i(wr_overflow), b2i(wr_en && w_occ_prev == DEPTH));
                end
                if (wr_ack) begin
                    sb.push_back(wr_data);
                    w_acc++;
                end
                if (exact_w) begin
                    chk("R5", "full", b2i(wr_full), b2i((w_acc - r_acc) == DEPTH));
                    chk("R5", "almost_full", b2i(wr_almost_full), b2i((w_acc - r_acc) >= DEPTH - 1));
                    chk("R4", "wr_level", int'(wr_level), w_occ_prev);
                    chk("R6", "prog_full", b2i(wr_prog_full), b2i(w_occ_prev >= PF));
                end
            end
        end
        w_occ_prev = w_acc - r_acc;
    end

    // read-side monitor, 1 ns after each read edge
    always @(posedge rclk) begin
        #1;
        if (!rst) begin
            if (rd_en) chk("R8", "valid xor underflow", b2i(rd_valid ^ rd_underflow), 1);
            else       chk("R7", "idle strobes", b2i(rd_valid | rd_underflow), 0);
            if (exact_r) chk("R7", "valid expected", b2i(rd_valid), b2i(rd_en && r_occ_prev > 0));
            if (rd_underflow) chk("R8", "data held on underflow", int'(rd_data), int'(last_dout));
            if (rd_valid) begin
                if (sb.size() == 0) chk("R11", "read with empty model", 1, 0);
                else chk("R7 R11", "read data order", int'(rd_data), int'(sb.pop_front()));
                r_acc++;
            end
            if (exact_r) begin
                chk("R9", "empty", b2i(rd_empty), b2i((w_acc - r_acc) == 0));
                chk("R9", "almost_empty", b2i(rd_almost_empty), b2i((w_acc - r_acc) == 1));
                chk("R10", "rd_level", int'(rd_level), r_occ_prev);
                chk("R10", "prog_empty", b2i(rd_prog_empty), b2i(r_occ_prev <= PE));
            end
            last_dout = rd_data;
        end
        r_occ_prev = w_acc - r_acc;
    end

    task automatic rand_traffic(input int ncyc, input int wp, input int rp);
        fork
            begin
                for (int i = 0; i < ncyc; i++) begin
                    @(negedge wclk);
                    wr_en   = (($urandom % 100) < wp);
                    wr_data = DW'($urandom);
                end
                @(negedge wclk) wr_en = 1'b0;
            end
            begin
                for (int i = 0; i < (ncyc * 5) / 7; i++) begin
                    @(negedge rclk);
                    rd_en = (($urandom % 100) < rp);
                end
                @(negedge rclk) rd_en = 1'b0;
            end
        join
    endtask

    task automatic drain_exact();
        repeat (10) @(negedge rclk);
        exact_r = 1;
        for (int i = 0; i < DEPTH + 2; i++) begin
            @(negedge rclk);
            rd_en = 1'b1;
        end
        @(negedge rclk) rd_en = 1'b0;
        repeat (4) @(negedge rclk);
        exact_r = 0;
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'd2024);
        // reset state
        repeat (20) @(negedge wclk);
        chk("R1", "reset full flags", int'({wr_full, wr_almost_full, wr_prog_full}), 7);
        chk("R1", "reset wr_level", int'(wr_level), 0);
        chk("R1", "reset wr strobes", b2i(wr_ack | wr_overflow), 0);
        chk("R9", "reset empty", int'({rd_empty, rd_almost_empty}), 2);
        chk("R10", "reset rd_level", int'(rd_level), 0);
        chk("R10", "reset prog_empty", b2i(rd_prog_empty), 1);
        chk("R7", "reset rd strobes", b2i(rd_valid | rd_underflow), 0);

        // release with a write held through recovery (R1)
        rst = 1'b0; wr_en = 1'b1; wr_data = 8'hA5;
        repeat (6) @(negedge wclk);
        wr_en = 1'b0;

        // directed fill past full: R3 R4 R5 R6
        repeat (10) @(negedge wclk);
        exact_w = 1;
        for (int i = 0; i < DEPTH + 1; i++) begin
            @(negedge wclk);
            wr_en = 1'b1;
            wr_data = DW'($urandom);
        end
        @(negedge wclk) wr_en = 1'b0;
        repeat (4) @(negedge wclk);
        exact_w = 0;

        // directed drain past empty: R7 R8 R9 R10
        drain_exact();

        // concurrent random traffic: R11
        rand_traffic(3000, 80, 30);
        rand_traffic(3000, 30, 90);
        rand_traffic(2000, 60, 60);
        drain_exact();
        chk("R11", "model empty at end", sb.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400us;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule